// File: doc/BRIEF.md
# Single-Cell Protection State Controller

This controller decides how the pass switch of a one-cell lithium-ion pack is driven. It does not see analog voltages. It sees comparator results that are already digitized, plus a slow timebase tick. From these it schedules periodic cell-voltage samples and qualifies three kinds of fault. An overcharge fault needs a long run of high samples. An overdischarge fault needs two low samples in a row. A discharge over-current fault needs several ticks of persistence. The result is a two-bit switch-mode code that tells the gate driver which of four modes to use: fully on, discharge-only regulation, charge-only regulation, or off.

An overcharged cell can still be discharged. An overdischarged cell puts the block to sleep, with the switch open, until a charger appears. The block then allows charge current only until the cell passes the higher recovery level. An over-current trip holds the switch off until the load is removed, which shows up as the pack-minus node being pulled close to the cell negative terminal. A thermal flag overrides every other condition. A two-bit variant select chooses one of four overcharge threshold pairs, and the chosen index is sent to the analog side.

Top module: `cellprot_guard`

## Requirements
- R1: While reset is held, and after it is released, swMode reads 2'b01 (fully on), sleep reads 0 and sampleEn reads 0.
- R2: sampleEn is high for exactly one clock, in the cycle after every SAMPLE_PERIOD-th tick. The voltage flags are read only in that cycle.
- R3: After OV_SAMPLES consecutive samples with ovAbove high, swMode becomes 2'b10 (discharge only). A sample with ovAbove low restarts the count.
- R4: Discharge-only mode returns to 2'b01 only at a sample where ovBelowRec is high. If ovAbove is low and ovBelowRec is also low, the mode stays 2'b10.
- R5: After UV_SAMPLES consecutive samples with uvBelow high, swMode becomes 2'b00 and sleep becomes 1. A single low sample between normal samples is ignored.
- R6: While asleep, sampleEn stays low, ticks have no effect, and the block keeps sleep high until chargerSeen goes high.
- R7: chargerSeen in sleep clears sleep and sets swMode to 2'b11 (charge only). The mode returns to 2'b01 only at a sample where uvAboveRec is high.
- R8: If ocHigh stays high over OC_TICKS consecutive ticks, swMode becomes 2'b00. Any cycle with ocHigh low restarts the count.
- R9: After an over-current trip, swMode stays 2'b00 until packNear goes high, and then returns to 2'b01.
- R10: hotFlag forces swMode to 2'b00 from the next clock, from any state. When hotFlag clears, the mode goes back to 2'b01. If an over-current trip is still latched, it stays 2'b00 until packNear instead.
- R11: threshSel equals the value of variantSel one clock earlier, for all four values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock timebase pulse |
| variantSel | input | 2 | Threshold pair select |
| ovAbove | input | 1 | Cell above overcharge entry level (valid at sample) |
| ovBelowRec | input | 1 | Cell below overcharge recovery level (valid at sample) |
| uvBelow | input | 1 | Cell below overdischarge entry level (valid at sample) |
| uvAboveRec | input | 1 | Cell above overdischarge recovery level (valid at sample) |
| ocHigh | input | 1 | Discharge current above limit |
| packNear | input | 1 | Pack-minus pulled near cell negative (load gone) |
| chargerSeen | input | 1 | Charger detected |
| hotFlag | input | 1 | Die over temperature |
| swMode | output | 2 | 00 off, 01 on, 10 discharge only, 11 charge only |
| sampleEn | output | 1 | Divider enable / sample strobe |
| sleep | output | 1 | Low-power sleep indication |
| threshSel | output | 2 | Selected threshold pair index |

## Verification
The assertions assume that tick is never high in two consecutive clocks. This keeps the sample strobe a single isolated pulse. They also assume the comparator flags stay steady for at least a clock around each change. The stimulus raises tick for one clock and then leaves several idle clocks. It changes flags only on the falling edge, and only between tick pulses. The bench uses a reduced configuration so that every fault path and every variant select can be swept in a short run.

// File: rtl/cellprot_pkg.sv
package cellprot_pkg;

  // Switch mode encoding driven to the gate control
  localparam logic [1:0] SW_OFF = 2'b00;
  localparam logic [1:0] SW_ON  = 2'b01;
  localparam logic [1:0] SW_DSG = 2'b10;
  localparam logic [1:0] SW_CHG = 2'b11;

  typedef enum logic [2:0] {
    ST_NORM = 3'd0,
    ST_OVP  = 3'd1,
    ST_UVS  = 3'd2,
    ST_UVC  = 3'd3,
    ST_OCL  = 3'd4,
    ST_HOT  = 3'd5
  } protState_e;

  // Control to datapath
  typedef struct packed {
    logic holdSample;
    logic clrRuns;
  } ctlStrobe_t;

  // Datapath to control
  typedef struct packed {
    logic ovQual;
    logic uvQual;
    logic ocQual;
    logic ovRecover;
    logic uvRecover;
  } dpEvent_t;

endpackage

// File: rtl/cellprot_debounce.sv
module cellprot_debounce #(
  parameter int LIMIT   = 2,
  parameter bit IMM_CLR = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic step,
  input  logic level,
  output logic qual
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (clr) begin
      runCnt <= '0;
    end else if (IMM_CLR && !level) begin
      runCnt <= '0;
    end else if (step) begin
      if (!level)            runCnt <= '0;
      else if (runCnt != LIM) runCnt <= runCnt + 1'b1;
    end
  end

  assign qual = (runCnt == LIM);
endmodule

// File: rtl/cellprot_timers.sv
module cellprot_timers
  import cellprot_pkg::*;
#(
  parameter int SAMPLE_PERIOD = 8,
  parameter int OV_SAMPLES    = 125,
  parameter int UV_SAMPLES    = 2,
  parameter int OC_TICKS      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] variantSel,
  input  logic       ovAbove,
  input  logic       ovBelowRec,
  input  logic       uvBelow,
  input  logic       uvAboveRec,
  input  logic       ocHigh,
  input  ctlStrobe_t strobe,
  output dpEvent_t   ev,
  output logic       sampleEn,
  output logic [1:0] threshSel
);
  localparam int SW = (SAMPLE_PERIOD > 2) ? $clog2(SAMPLE_PERIOD) : 1;
  localparam logic [SW-1:0] LAST = SW'(SAMPLE_PERIOD - 1);

  logic [SW-1:0] sampCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampCnt  <= '0;
      sampleEn <= 1'b0;
    end else begin
      sampleEn <= 1'b0;
      if (strobe.holdSample) begin
        sampCnt <= '0;
      end else if (tick) begin
        if (sampCnt == LAST) begin
          sampCnt  <= '0;
          sampleEn <= 1'b1;
        end else begin
          sampCnt <= sampCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) threshSel <= variantSel;

  cellprot_debounce #(.LIMIT(OV_SAMPLES), .IMM_CLR(1'b0)) u_ovRun (
    .clk(clk), .rstN(rstN), .clr(strobe.clrRuns), .step(sampleEn),
    .level(ovAbove), .qual(ev.ovQual));

  cellprot_debounce #(.LIMIT(UV_SAMPLES), .IMM_CLR(1'b0)) u_uvRun (
    .clk(clk), .rstN(rstN), .clr(strobe.clrRuns), .step(sampleEn),
    .level(uvBelow), .qual(ev.uvQual));

  cellprot_debounce #(.LIMIT(OC_TICKS), .IMM_CLR(1'b1)) u_ocRun (
    .clk(clk), .rstN(rstN), .clr(strobe.clrRuns), .step(tick),
    .level(ocHigh), .qual(ev.ocQual));

  assign ev.ovRecover = sampleEn & ovBelowRec;
  assign ev.uvRecover = sampleEn & uvAboveRec;
endmodule

// File: rtl/cellprot_ctrl.sv
module cellprot_ctrl
  import cellprot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpEvent_t   ev,
  input  logic       chargerSeen,
  input  logic       packNear,
  input  logic       hotFlag,
  output ctlStrobe_t strobe,
  output logic [1:0] swMode,
  output logic       sleep
);
  protState_e state, nextState;
  logic ocLatch;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_NORM: begin
        if (ev.ocQual)      nextState = ST_OCL;
        else if (ev.uvQual) nextState = ST_UVS;
        else if (ev.ovQual) nextState = ST_OVP;
      end
      ST_OVP: begin
        if (ev.ocQual)         nextState = ST_OCL;
        else if (ev.ovRecover) nextState = ST_NORM;
      end
      ST_UVS:  if (chargerSeen)  nextState = ST_UVC;
      ST_UVC:  if (ev.uvRecover) nextState = ST_NORM;
      ST_OCL:  if (packNear)     nextState = ST_NORM;
      ST_HOT:  if (!hotFlag)     nextState = ocLatch ? ST_OCL : ST_NORM;
      default: nextState = ST_NORM;
    endcase
    if (hotFlag) nextState = ST_HOT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_NORM;
      ocLatch <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState == ST_OCL)                          ocLatch <= 1'b1;
      else if (state == ST_OCL && nextState == ST_NORM) ocLatch <= 1'b0;
    end
  end

  always_comb begin
    strobe.holdSample = (state == ST_UVS);
    strobe.clrRuns    = (nextState != state) && (nextState != ST_HOT) && (state != ST_HOT);
    sleep             = (state == ST_UVS);
    unique case (state)
      ST_NORM: swMode = SW_ON;
      ST_OVP:  swMode = SW_DSG;
      ST_UVC:  swMode = SW_CHG;
      default: swMode = SW_OFF;
    endcase
  end
endmodule

// File: rtl/cellprot_guard.sv
module cellprot_guard
  import cellprot_pkg::*;
#(
  parameter int SAMPLE_PERIOD = 8,
  parameter int OV_SAMPLES    = 125,
  parameter int UV_SAMPLES    = 2,
  parameter int OC_TICKS      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] variantSel,
  input  logic       ovAbove,
  input  logic       ovBelowRec,
  input  logic       uvBelow,
  input  logic       uvAboveRec,
  input  logic       ocHigh,
  input  logic       packNear,
  input  logic       chargerSeen,
  input  logic       hotFlag,
  output logic [1:0] swMode,
  output logic       sampleEn,
  output logic       sleep,
  output logic [1:0] threshSel
);
  ctlStrobe_t strobe;
  dpEvent_t   ev;

  cellprot_timers #(
    .SAMPLE_PERIOD(SAMPLE_PERIOD), .OV_SAMPLES(OV_SAMPLES),
    .UV_SAMPLES(UV_SAMPLES), .OC_TICKS(OC_TICKS)
  ) u_timers (
    .clk(clk), .rstN(rstN), .tick(tick), .variantSel(variantSel),
    .ovAbove(ovAbove), .ovBelowRec(ovBelowRec), .uvBelow(uvBelow),
    .uvAboveRec(uvAboveRec), .ocHigh(ocHigh), .strobe(strobe), .ev(ev),
    .sampleEn(sampleEn), .threshSel(threshSel));

  cellprot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .chargerSeen(chargerSeen),
    .packNear(packNear), .hotFlag(hotFlag), .strobe(strobe),
    .swMode(swMode), .sleep(sleep));
endmodule

// File: rtl/cellprot_guard_chk.sv
module cellprot_guard_chk
  import cellprot_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] variantSel,
  input logic       chargerSeen,
  input logic       hotFlag,
  input logic [1:0] swMode,
  input logic       sampleEn,
  input logic       sleep,
  input logic [1:0] threshSel
);
  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |=> !sampleEn);

  // R6
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep && $past(sleep) |-> !sampleEn && swMode == SW_OFF);

  // R6
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep && !chargerSeen && !hotFlag |=> sleep);

  // R7
  charge_from_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swMode == SW_CHG) |-> $past(sleep));

  // R3
  dsg_from_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    swMode == SW_DSG && $past(swMode) != SW_DSG |-> $past(swMode) == SW_ON);

  // R10
  hot_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    hotFlag |=> swMode == SW_OFF);

  // R11
  thresh_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    threshSel == $past(variantSel));
endmodule

bind cellprot_guard cellprot_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .variantSel(variantSel), .chargerSeen(chargerSeen),
  .hotFlag(hotFlag), .swMode(swMode), .sampleEn(sampleEn), .sleep(sleep),
  .threshSel(threshSel));

// File: tb/cellprot_guard_tb.sv
`timescale 1ns/1ps
module cellprot_guard_tb;
  localparam int SP = 4;
  localparam int OVN = 5;
  localparam int UVN = 2;
  localparam int OCN = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [1:0] variantSel = 2'd0;
  logic ovAbove = 0, ovBelowRec = 0, uvBelow = 0, uvAboveRec = 0;
  logic ocHigh = 0, packNear = 0, chargerSeen = 0, hotFlag = 0;
  logic [1:0] swMode;
  logic sampleEn, sleep;
  logic [1:0] threshSel;

  int checks = 0;
  int errors = 0;
  int seCount = 0;

  always #4 clk = ~clk;

  cellprot_guard #(.SAMPLE_PERIOD(SP), .OV_SAMPLES(OVN), .UV_SAMPLES(UVN), .OC_TICKS(OCN)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .variantSel(variantSel),
    .ovAbove(ovAbove), .ovBelowRec(ovBelowRec), .uvBelow(uvBelow),
    .uvAboveRec(uvAboveRec), .ocHigh(ocHigh), .packNear(packNear),
    .chargerSeen(chargerSeen), .hotFlag(hotFlag), .swMode(swMode),
    .sampleEn(sampleEn), .sleep(sleep), .threshSel(threshSel));

  always @(negedge clk) if (sampleEn) seCount++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tk();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    idle(3);
  endtask

  task automatic samples(int n);
    for (int i = 0; i < n * SP; i++) tk();
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R1 during reset
    check("R1 swMode in reset", swMode, 1);
    check("R1 sleep in reset", sleep, 0);
    rstN = 1'b1;
    idle(2);
    check("R1 swMode after reset", swMode, 1);
    check("R1 sampleEn after reset", sampleEn, 0);

    // R11 exhaustive select sweep
    for (int v = 0; v < 4; v++) begin
      variantSel = 2'(v);
      idle(2);
      check("R11 threshSel", threshSel, v);
    end

    // R2 strobe cadence
    seCount = 0;
    for (int i = 0; i < SP - 1; i++) tk();
    check("R2 no strobe before period", seCount, 0);
    tk();
    check("R2 one strobe per period", seCount, 1);
    samples(2);
    check("R2 strobe count over three periods", seCount, 3);

    // R3 overcharge qualification with an interruption
    ovAbove = 1; samples(OVN - 2);
    ovAbove = 0; samples(1);
    ovAbove = 1; samples(OVN - 1);
    check("R3 one sample short", swMode, 1);
    samples(1);
    check("R3 discharge only", swMode, 2);

    // R4 hysteresis and recovery
    ovAbove = 0; ovBelowRec = 0; samples(2);
    check("R4 stays discharge only", swMode, 2);
    ovBelowRec = 1; samples(1);
    check("R4 recovered", swMode, 1);
    ovBelowRec = 0;

    // R5 undervoltage qualification
    uvBelow = 1; samples(1);
    uvBelow = 0; samples(1);
    uvBelow = 1; samples(1);
    check("R5 single low ignored", swMode, 1);
    check("R5 not asleep", sleep, 0);
    samples(1);
    check("R5 switch off", swMode, 0);
    check("R5 asleep", sleep, 1);
    uvBelow = 0;

    // R6 sleep holds, no strobes
    seCount = 0;
    samples(3);
    check("R6 no strobes in sleep", seCount, 0);
    check("R6 still asleep", sleep, 1);

    // R7 charger detection
    chargerSeen = 1; idle(3); chargerSeen = 0;
    check("R7 charge only", swMode, 3);
    check("R7 awake", sleep, 0);
    uvAboveRec = 0; samples(2);
    check("R7 stays charge only", swMode, 3);
    uvAboveRec = 1; samples(1);
    check("R7 back on", swMode, 1);
    uvAboveRec = 0;

    // R8 over-current persistence
    ocHigh = 1; for (int i = 0; i < OCN - 1; i++) tk();
    ocHigh = 0; idle(1);
    ocHigh = 1; for (int i = 0; i < OCN - 1; i++) tk();
    check("R8 interrupted run ignored", swMode, 1);
    tk();
    check("R8 tripped off", swMode, 0);
    ocHigh = 0;

    // R9 latch release
    for (int i = 0; i < 5; i++) tk();
    check("R9 latched without load removal", swMode, 0);
    packNear = 1; idle(3); packNear = 0;
    check("R9 released", swMode, 1);

    // R10 thermal override
    hotFlag = 1; idle(2);
    check("R10 hot off", swMode, 0);
    hotFlag = 0; idle(3);
    check("R10 hot cleared", swMode, 1);
    ocHigh = 1; for (int i = 0; i < OCN; i++) tk();
    ocHigh = 0;
    hotFlag = 1; idle(3);
    hotFlag = 0; idle(3);
    check("R10 latch kept after hot", swMode, 0);
    packNear = 1; idle(3); packNear = 0;
    check("R10 released after hot", swMode, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule